// File: doc/BRIEF.md
# Converter Serial Port with Pin-Strapped Mode Select

This block is the device-side serial port of a sampling converter. It watches three host pins (convert, serial-in and serial clock) through an oversampling system clock. It takes the finished 16-bit result and a one-cycle done pulse from the conversion sequencer and returns one bit of serial output. The output is modelled as a data bit plus a drive enable, so the pad three-state lives outside the block. A convert rising edge that arrives while the port is idle tells the sequencer to start, through a one-cycle start pulse.

No configuration register exists. The levels on the serial-in and clock pins, sampled at the convert rising edge, choose the operating mode. Select mode gives a chip-select style readout, where a low level on convert or serial-in enables the output. Chain mode turns the port into a 16-stage shift path so that several converters can share one data line. The same strapping also decides whether a start bit leads each readout. The start bit lets a host treat the end of conversion as an interrupt.

Top module: `conv_serial_port`

## Requirements
- R1: After reset, and until the first accepted convert rising edge, `sdo_oe` is 0 (`sdo_oe` = 1 means the output is driven). Clock edges and done pulses in this state do not change that.
- R2: At an accepted convert rising edge, `conv_start` pulses once. The port enters select mode if serial-in is 1 and chain mode if it is 0, and `sdo_oe` goes to 0.
- R3: In select mode, `sdo_oe` stays 0 while a conversion is in progress. Once the result is loaded, `sdo_oe` is 1 only while convert or serial-in is 0.
- R4: In select mode, if convert or serial-in is 0 in the cycle the done pulse is taken, the output first shows a start bit of 0. The next 16 enabled clock falling edges present result bits 15 down to 0, and the 17th ends the readout with `sdo_oe` = 0.
- R5: In select mode without a start bit, result bit 15 is shown as soon as the output is enabled. Each enabled falling edge presents the next lower bit, and the 16th ends the readout with `sdo_oe` = 0.
- R6: In chain mode during a conversion, with convert at 0: if no start bit was chosen, the output drives 0 while serial-in is 0 and is off while serial-in is 1. With a start bit chosen, the output drives and follows serial-in. With convert at 1 the output is off.
- R7: Chain mode with the clock pin 0 at the convert edge has no start bit. At done the output drives result bit 15. Each falling edge shifts serial-in into the path, so a level given at falling edge n appears on the output after falling edge n+15, and result bits precede it in descending order.
- R8: Chain mode with the clock pin 1 at the convert edge shows a start bit of 1 at done. The first falling edge removes the start bit without sampling serial-in. Every later falling edge shifts as in R7.
- R9: Clock falling edges that arrive during a conversion, or while the select-mode output is disabled, leave the output sequence unchanged.
- R10: A convert rising edge during a conversion is ignored, with no start pulse and no mode change. A done pulse with no conversion pending is ignored. A new conversion started in the middle of a readout discards the partial readout, and the next readout is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_pin | input | 1 | Convert pin from the host (asynchronous) |
| sdi_pin | input | 1 | Serial-in pin: mode strap, select input, or chain data |
| sck_pin | input | 1 | Serial clock pin from the host (asynchronous) |
| conv_done | input | 1 | One-cycle pulse from the sequencer when the result is ready |
| conv_result | input | DATA_W | Conversion result, valid with conv_done |
| conv_start | output | 1 | One-cycle pulse asking the sequencer to start |
| sdo_data | output | 1 | Serial output bit |
| sdo_oe | output | 1 | Serial output drive enable (1 = driven) |

## Verification
The hardest states to reach are the chain-mode start-bit path and the 4-wire select readout, where serial-in toggles in the middle of a readout. Both depend on the serial-in and clock levels at the convert edge and again at the done pulse. The bench reaches them by parking the pins at chosen levels before each edge and giving the sync chain time to settle. It then drives clock falls while the output is disabled and checks that the next enabled bit is still the one left pending. For chain mode, a known serial-in pattern is fed through 32 or more falls, and the bench checks each returned bit against the pattern shifted by the 15- or 16-edge delay.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

  typedef enum logic {
    PM_SELECT = 1'b0,
    PM_CHAIN  = 1'b1
  } port_mode_e;

  // Number of enabled falling edges that make up one select-mode readout
  function automatic int read_len(input int width, input logic lead_bit);
    return lead_bit ? width + 1 : width;
  endfunction

endpackage

// File: rtl/csp_pin_sync.sv
module csp_pin_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o
);

  genvar p;
  generate
    for (p = 0; p < N; p++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_i[p]};
      end
      assign pin_o[p] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/csp_ctrl.sv
module csp_ctrl
  import ser_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnv_rise,
  input  logic       conv_done,
  input  logic       cnv_lvl,
  input  logic       sdi_lvl,
  input  logic       sck_lvl,
  input  logic       read_end,
  output logic       start_ev,
  output logic       load_ev,
  output logic       conv_q,
  output logic       live_q,
  output port_mode_e mode_q,
  output logic       lead_q,
  output logic       lead_at_load
);

  assign start_ev = cnv_rise & ~conv_q;
  assign load_ev  = conv_done & conv_q;
  // Select mode decides on the start bit at conversion end; chain mode at the edge
  assign lead_at_load = (mode_q == PM_CHAIN) ? lead_q : (~cnv_lvl | ~sdi_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_q <= 1'b0;
      live_q <= 1'b0;
      mode_q <= PM_SELECT;
      lead_q <= 1'b0;
    end else if (start_ev) begin
      conv_q <= 1'b1;
      live_q <= 1'b0;
      mode_q <= sdi_lvl ? PM_SELECT : PM_CHAIN;
      lead_q <= sdi_lvl ? 1'b0 : sck_lvl;
    end else if (load_ev) begin
      conv_q <= 1'b0;
      live_q <= 1'b1;
      lead_q <= lead_at_load;
    end else if (read_end) begin
      live_q <= 1'b0;
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> conv_q && !live_q &&
                 (mode_q == ($past(sdi_lvl) ? PM_SELECT : PM_CHAIN)));

  // R10
  busy_edge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise && conv_q && !conv_done |=> conv_q && $stable(mode_q) && $stable(lead_q));

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_q && live_q));

endmodule

// File: rtl/csp_shifter.sv
module csp_shifter #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic          step,
  input  logic          chain_fill,
  input  logic          sdi_lvl,
  input  logic          lead_in,
  input  logic          lead_val,
  input  logic [W-1:0]  data_in,
  output logic          sdo_bit,
  output logic [CW-1:0] edge_cnt
);

  logic [W-1:0] sr_q;
  logic         head_v_q;
  logic         head_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      head_v_q <= 1'b0;
      head_b_q <= 1'b0;
      edge_cnt <= '0;
    end else if (clear) begin
      sr_q     <= '0;
      head_v_q <= 1'b0;
      head_b_q <= 1'b0;
      edge_cnt <= '0;
    end else if (load) begin
      sr_q     <= data_in;
      head_v_q <= lead_in;
      head_b_q <= lead_val;
      edge_cnt <= '0;
    end else if (step) begin
      if (head_v_q) head_v_q <= 1'b0;
      else          sr_q <= {sr_q[W-2:0], chain_fill ? sdi_lvl : 1'b0};
      if (edge_cnt != '1) edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assign sdo_bit = head_v_q ? head_b_q : sr_q[W-1];

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear && !load && !step |=> $stable(sr_q) && $stable(head_v_q) && $stable(edge_cnt));

endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import ser_port_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_pin,
  input  logic              sdi_pin,
  input  logic              sck_pin,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result,
  output logic              conv_start,
  output logic              sdo_data,
  output logic              sdo_oe
);

  localparam int CW      = $clog2(DATA_W + 2);
  localparam int PIN_N   = 3;
  localparam int IDX_CNV = 2;
  localparam int IDX_SDI = 1;
  localparam int IDX_SCK = 0;

  logic [PIN_N-1:0] pins_s;
  logic cnv_s, sdi_s, sck_s;
  logic cnv_q, sck_q;
  logic cnv_rise, sck_fall;
  logic start_ev, load_ev, conv_q, live_q, lead_q, lead_at_load;
  port_mode_e mode_q;
  logic sel_en, step, read_end, sdo_bit;
  logic [CW-1:0] edge_cnt;

  csp_pin_sync #(.N(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({cnv_pin, sdi_pin, sck_pin}),
    .pin_o (pins_s)
  );

  assign cnv_s = pins_s[IDX_CNV];
  assign sdi_s = pins_s[IDX_SDI];
  assign sck_s = pins_s[IDX_SCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cnv_q <= cnv_s;
      sck_q <= sck_s;
    end
  end

  assign cnv_rise = cnv_s & ~cnv_q;
  assign sck_fall = sck_q & ~sck_s;

  csp_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnv_rise     (cnv_rise),
    .conv_done    (conv_done),
    .cnv_lvl      (cnv_s),
    .sdi_lvl      (sdi_s),
    .sck_lvl      (sck_s),
    .read_end     (read_end),
    .start_ev     (start_ev),
    .load_ev      (load_ev),
    .conv_q       (conv_q),
    .live_q       (live_q),
    .mode_q       (mode_q),
    .lead_q       (lead_q),
    .lead_at_load (lead_at_load)
  );

  // Select-mode output enable: either strobe low
  assign sel_en   = ~cnv_s | ~sdi_s;
  assign step     = sck_fall & live_q & ((mode_q == PM_CHAIN) | sel_en);
  assign read_end = step & (mode_q == PM_SELECT) &
                    ((int'(edge_cnt) + 1) == read_len(DATA_W, lead_q));

  csp_shifter #(.W(DATA_W), .CW(CW)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ev),
    .load       (load_ev),
    .step       (step),
    .chain_fill (mode_q == PM_CHAIN),
    .sdi_lvl    (sdi_s),
    .lead_in    (lead_at_load),
    .lead_val   (mode_q == PM_CHAIN),
    .data_in    (conv_result),
    .sdo_bit    (sdo_bit),
    .edge_cnt   (edge_cnt)
  );

  assign conv_start = start_ev;
  assign sdo_data   = conv_q ? sdi_s : sdo_bit;
  assign sdo_oe     = conv_q ? ((mode_q == PM_CHAIN) & ~cnv_s & (~sdi_s | lead_q))
                             : (live_q & ((mode_q == PM_CHAIN) | sel_en));

  // R3
  sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q && (mode_q == PM_SELECT) |-> !sdo_oe);

  // R6
  chain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_q && (mode_q == PM_CHAIN) && !cnv_s && !sdi_s |-> sdo_oe && !sdo_data);

  // R5
  read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && (mode_q == PM_SELECT) |-> int'(edge_cnt) < read_len(DATA_W, lead_q));

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_q && !live_q |-> !sdo_oe);

endmodule

// File: tb/conv_serial_port_test.sv
`timescale 1ns/1ps
module conv_serial_port_test;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnv = 1'b0, sdi = 1'b0, sck = 1'b0, done = 1'b0;
  logic [15:0] res = '0;
  wire conv_start, sdo_data, sdo_oe;

  int n_tests = 0, n_fail = 0, n_starts = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  conv_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cnv_pin(cnv), .sdi_pin(sdi), .sck_pin(sck),
    .conv_done(done), .conv_result(res), .conv_start(conv_start),
    .sdo_data(sdo_data), .sdo_oe(sdo_oe)
  );

  always @(posedge clk) if (conv_start) n_starts++;

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic fall();
    sck = 1'b1; settle();
    sck = 1'b0; settle();
  endtask

  task automatic pulse_done(input logic [15:0] v);
    @(negedge clk); res = v; done = 1'b1;
    @(negedge clk); done = 1'b0;
    settle();
  endtask

  task automatic start_conv(input logic mode_sdi, input logic sck_lvl);
    cnv = 1'b0; settle();
    sdi = mode_sdi; sck = sck_lvl; settle();
    cnv = 1'b1; settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    logic [15:0] vals [5] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h8001, 16'h1234};
    int s0;
    logic [15:0] p;
    logic sent [40];

    settle();
    rst_n = 1'b1; settle();
    // R1: idle after reset, stray activity ignored
    check("R1 reset oe", sdo_oe, 0);
    fall(); pulse_done(16'hFFFF);
    check("R1 idle after sck/done", sdo_oe, 0);
    check("R1 no start", n_starts, 0);

    // Select mode, no start bit (3-wire, convert held high)
    foreach (vals[i]) begin
      s0 = n_starts;
      start_conv(1'b1, 1'b0);
      check("R2 start pulse", n_starts, s0 + 1);
      check("R2 oe after edge", sdo_oe, 0);
      fall(); // R9: ignored during conversion
      pulse_done(vals[i]);
      check("R3 disabled while strobes high", sdo_oe, 0);
      cnv = 1'b0; settle();
      check("R5 msb oe", sdo_oe, 1);
      check("R5 msb", sdo_data, vals[i][15]);
      for (int k = 1; k <= 15; k++) begin
        fall();
        check("R5 bit", sdo_data, vals[i][15-k]);
        check("R5 oe", sdo_oe, 1);
      end
      fall();
      check("R5 off after 16th", sdo_oe, 0);
    end

    // Select mode with start bit (convert low at conversion end)
    foreach (vals[i]) begin
      start_conv(1'b1, 1'b0);
      cnv = 1'b0; settle();
      check("R3 quiet while converting", sdo_oe, 0);
      fall(); // R9
      pulse_done(vals[i]);
      check("R4 start oe", sdo_oe, 1);
      check("R4 start bit", sdo_data, 0);
      for (int k = 0; k < 16; k++) begin
        fall();
        check("R4 bit", sdo_data, vals[i][15-k]);
      end
      check("R4 oe before 17th", sdo_oe, 1);
      fall();
      check("R4 off after 17th", sdo_oe, 0);
    end

    // 4-wire select: serial-in acts as the select
    start_conv(1'b1, 1'b0);
    pulse_done(16'h6C39);
    check("R3 oe with both high", sdo_oe, 0);
    fall();
    sdi = 1'b0; settle();
    check("R9 msb after ignored fall", sdo_data, 1'b0);
    fall();
    check("R5 bit14", sdo_data, 1'b1);
    sdi = 1'b1; settle();
    check("R3 oe released", sdo_oe, 0);
    fall(); fall();
    sdi = 1'b0; settle();
    check("R9 bit14 held", sdo_data, 1'b1);
    for (int k = 2; k <= 15; k++) begin
      fall();
      check("R5 4-wire bit", sdo_data, 16'h6C39 >> (15 - k) & 1);
    end
    fall();
    check("R5 4-wire end", sdo_oe, 0);
    pulse_done(16'hFFFF);
    check("R10 stray done", sdo_oe, 0);
    sdi = 1'b1;

    // Chain mode, no start bit
    foreach (vals[i]) begin
      start_conv(1'b0, 1'b0);
      check("R2 chain oe after edge", sdo_oe, 0);
      cnv = 1'b0; sdi = 1'b0; settle();
      check("R6 drive low oe", sdo_oe, 1);
      check("R6 drive low", sdo_data, 0);
      sdi = 1'b1; settle();
      check("R6 off when sdi high", sdo_oe, 0);
      sdi = 1'b0; settle();
      pulse_done(vals[i]);
      check("R7 msb", sdo_data, vals[i][15]);
      check("R7 oe", sdo_oe, 1);
      p = vals[i] ^ 16'hC3A5;
      for (int j = 1; j <= 32; j++) begin
        sdi = p[j % 16]; sent[j] = p[j % 16];
        fall();
        if (j <= 15) check("R7 result bit", sdo_data, vals[i][15-j]);
        else         check("R7 passed bit", sdo_data, sent[j-15]);
      end
    end

    // Chain mode with start bit
    foreach (vals[i]) begin
      start_conv(1'b0, 1'b1);
      sck = 1'b0; settle();  // R9: fall during conversion
      cnv = 1'b0; sdi = 1'b1; settle();
      check("R6 follow high", sdo_data, 1);
      check("R6 follow oe", sdo_oe, 1);
      sdi = 1'b0; settle();
      check("R6 follow low", sdo_data, 0);
      s0 = n_starts;
      cnv = 1'b1; settle();
      check("R10 edge ignored", n_starts, s0);
      check("R6 off with convert high", sdo_oe, 0);
      cnv = 1'b0; settle();
      pulse_done(vals[i]);
      check("R8 start bit", sdo_data, 1);
      p = vals[i] ^ 16'h5A0F;
      for (int j = 1; j <= 34; j++) begin
        sdi = p[j % 16]; sent[j] = p[j % 16];
        fall();
        if (j == 1)       check("R8 msb", sdo_data, vals[i][15]);
        else if (j <= 16) check("R8 result bit", sdo_data, vals[i][16-j]);
        else              check("R8 passed bit", sdo_data, sent[j-15]);
      end
    end

    // New conversion in the middle of a readout
    start_conv(1'b1, 1'b0);
    pulse_done(16'h0F0F);
    cnv = 1'b0; settle();
    fall(); fall(); fall();
    s0 = n_starts;
    cnv = 1'b1; settle();
    check("R10 restart pulse", n_starts, s0 + 1);
    check("R10 restart oe", sdo_oe, 0);
    pulse_done(16'hB00D);
    cnv = 1'b0; settle();
    check("R10 fresh msb", sdo_data, 1);
    for (int k = 1; k <= 15; k++) begin
      fall();
      check("R10 fresh bit", sdo_data, 16'hB00D >> (15 - k) & 1);
    end
    check("R10 oe before end", sdo_oe, 1);
    fall();
    check("R10 full length", sdo_oe, 0);

    report();
  end

endmodule